// File: doc/BRIEF.md
# Sprite Serializer and Pixel Compositor

This block sits at the end of a tile-and-sprite video pipeline. On every memory slot it emits two pixels as 4-bit color indices. Up to four sprite lanes each hold a horizontal start position, a color and a 16-bit pattern word. A lane starts emitting pattern bits only once the pixel position reaches its start position. Those sprite bits are merged with a background pattern byte and its color byte. The background lookup has two flavors: a graphics flavor, where the color byte supplies the foreground and background nibbles, and a text flavor, where a single backdrop/text-color register supplies both.

Sprite evaluation logic loads the lanes one at a time. The background fetch logic loads the pattern and color bytes. The slot sequencer pulses a slot strobe along with the slot counter and an active-area flag. Outside the active area the block emits the backdrop color, but sprite lanes keep serializing so that sprites placed left of the visible edge arrive correctly. Whenever two sprites put a set pattern bit on the same pixel, a sticky collision flag is raised.

Top module: `sprite_pixel_compositor`

## Requirements
- R1: After a synchronous reset `pix_valid`, `pix_color` and `coll_flag` are 0, every sprite lane pattern is 0, and the background pattern and color bytes are 0.
- R2: A slot strobe produces, on the next clock, `pix_valid` high for one cycle and two new pixels. The first pixel is in `pix_color[3:0]` and the second in `pix_color[7:4]`. With no strobe, `pix_valid` is low and `pix_color` holds its value.
- R3: The first pixel's position is twice the slot counter. When that value exceeds 294, 512 is subtracted from it. The second pixel's position is one more than the first.
- R4: For each pixel, a lane whose signed start position is less than or equal to the pixel position outputs bit 15 of its pattern word and then shifts the word left by one. A lane whose start position is greater than the pixel position outputs 0 and does not shift.
- R5: Among lanes that output a 1 with a nonzero color, the lowest-numbered lane sets the pixel color.
- R6: A lane whose color is 0 is transparent. Its set bits do not hide the background, but they do still count toward collisions.
- R7: In the active area, when no lane supplies a color, background pattern bit 7 picks color byte bits [7:4] when it is 1 and bits [3:0] when it is 0. The pattern byte shifts left by one for every active pixel, whether or not a sprite covers that pixel.
- R8: In graphics flavor, a background nibble of 0 selected by a pattern 0 bit is replaced by backdrop bits [3:0].
- R9: In text flavor (`text_mode`=1), a pattern 1 bit gives backdrop bits [7:4] and a pattern 0 bit gives backdrop bits [3:0].
- R10: When `active`=0, both pixels are backdrop bits [3:0] and the background pattern is not consumed. Sprite lanes still shift and still raise collisions.
- R11: Two or more lanes outputting a 1 at the same pixel sets `coll_flag`, which stays set until `coll_clr`. When a clear and a new collision fall in the same cycle, the flag ends up set.
- R12: A background load or sprite load in the same cycle as a slot strobe takes effect for that slot, so the newly loaded values are the ones consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_en | input | 1 | Slot strobe, two pixels per strobe |
| hslot | input | 8 | Slot counter |
| active | input | 1 | Active-area flag; 0 selects the border |
| text_mode | input | 1 | 1 selects text flavor |
| backdrop | input | 8 | Text foreground [7:4], backdrop [3:0] |
| spr_load | input | 1 | Load one sprite lane |
| spr_sel | input | 2 | Lane to load |
| spr_x | input | 10 | Signed start position |
| spr_color | input | 4 | Lane color, 0 is transparent |
| spr_pattern | input | 16 | Pattern word, bit 15 first |
| bg_load | input | 1 | Load background bytes |
| bg_pattern | input | 8 | Background pattern, bit 7 first |
| bg_color | input | 8 | Foreground [7:4], background [3:0] |
| coll_clr | input | 1 | Clear collision flag |
| pix_valid | output | 1 | New pixel pair present |
| pix_color | output | 8 | Pixel pair, first in [3:0] |
| coll_flag | output | 1 | Sticky sprite collision flag |

## Verification
Two pairs of events can land in the same cycle. The first is a collision clear arriving on the very slot where two overlapping lanes both emit a 1. The second is a background or sprite reload arriving on the same strobe that consumes those bits. The bench provokes both on purpose, first in directed steps and then in a long stretch of random stimulus where all strobes are independent. It judges the outcome each clock against a behavioural model that applies loads before pixel evaluation, and that applies a new collision after the clear.

// File: rtl/spc_pkg.sv
package spc_pkg;

  typedef enum logic [1:0] {
    SRC_BORDER = 2'd0,
    SRC_SPRITE = 2'd1,
    SRC_FORE   = 2'd2,
    SRC_BACK   = 2'd3
  } pix_src_e;

  // first pixel position of a slot, folded to negative past the limit
  function automatic int slot_origin(input int hs, input int slot_w, input int wrap_lim);
    int b;
    b = hs * 2;
    if (b > wrap_lim) b = b - (2 << slot_w);
    return b;
  endfunction

endpackage

// File: rtl/spc_sprite_lane.sv
module spc_sprite_lane #(
  parameter int PAT_W = 16,
  parameter int POS_W = 10,
  parameter int COL_W = 4,
  parameter int PPS   = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          slot_en,
  input  logic                          load,
  input  logic signed [POS_W-1:0]       ld_x,
  input  logic [COL_W-1:0]              ld_color,
  input  logic [PAT_W-1:0]              ld_pat,
  input  logic [PPS-1:0][POS_W-1:0]     pos,
  output logic [PPS-1:0]                bits,
  output logic [COL_W-1:0]              color
);

  logic signed [POS_W-1:0] x_q, x_e;
  logic [COL_W-1:0]        color_q;
  logic [PAT_W-1:0]        pat_q, pat_e, pat_nx;

  always_comb begin
    logic [PAT_W-1:0] w;
    x_e   = load ? ld_x : x_q;
    color = load ? ld_color : color_q;
    pat_e = load ? ld_pat : pat_q;
    w     = pat_e;
    for (int p = 0; p < PPS; p++) begin
      if ($signed(pos[p]) >= x_e) begin
        bits[p] = w[PAT_W-1];
        w       = {w[PAT_W-2:0], 1'b0};
      end else begin
        bits[p] = 1'b0;
      end
    end
    pat_nx = w;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q     <= '0;
      color_q <= '0;
      pat_q   <= '0;
    end else begin
      if (load) begin
        x_q     <= ld_x;
        color_q <= ld_color;
      end
      if (slot_en)   pat_q <= pat_nx;
      else if (load) pat_q <= ld_pat;
    end
  end

  // R4
  lane_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (slot_en && !load && ($signed(pos[PPS-1]) < x_q)) |=> $stable(pat_q));

  // R2
  lane_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!slot_en && !load) |=> $stable(pat_q));

endmodule

// File: rtl/spc_bg_shift.sv
module spc_bg_shift #(
  parameter int PAT_W = 8,
  parameter int CB_W  = 8,
  parameter int PPS   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [PAT_W-1:0] ld_pat,
  input  logic [CB_W-1:0]  ld_col,
  input  logic             consume,
  output logic [PPS-1:0]   msb,
  output logic [CB_W-1:0]  col
);

  logic [PAT_W-1:0] pat_q, pat_e, pat_nx;
  logic [CB_W-1:0]  col_q;

  always_comb begin
    logic [PAT_W-1:0] w;
    pat_e = load ? ld_pat : pat_q;
    col   = load ? ld_col : col_q;
    w     = pat_e;
    for (int p = 0; p < PPS; p++) begin
      msb[p] = w[PAT_W-1];
      w      = {w[PAT_W-2:0], 1'b0};
    end
    pat_nx = w;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pat_q <= '0;
      col_q <= '0;
    end else begin
      if (consume)   pat_q <= pat_nx;
      else if (load) pat_q <= ld_pat;
      if (load) col_q <= ld_col;
    end
  end

  // R10
  bg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!consume && !load) |=> $stable(pat_q));

endmodule

// File: rtl/spc_pix_mux.sv
module spc_pix_mux
  import spc_pkg::*;
#(
  parameter int COL_W = 4
) (
  input  logic               active,
  input  logic               text_mode,
  input  logic [2*COL_W-1:0] backdrop,
  input  logic [2*COL_W-1:0] col_byte,
  input  logic               pat_bit,
  input  logic               spr_hit,
  input  logic [COL_W-1:0]   spr_col,
  output logic [COL_W-1:0]   pix,
  output pix_src_e           src
);

  logic [COL_W-1:0] fg, bg;

  always_comb begin
    if (text_mode) begin
      fg = backdrop[2*COL_W-1:COL_W];
      bg = backdrop[COL_W-1:0];
    end else begin
      fg = col_byte[2*COL_W-1:COL_W];
      bg = (col_byte[COL_W-1:0] == '0) ? backdrop[COL_W-1:0] : col_byte[COL_W-1:0];
    end
    if (!active) begin
      src = SRC_BORDER;
      pix = backdrop[COL_W-1:0];
    end else if (spr_hit) begin
      src = SRC_SPRITE;
      pix = spr_col;
    end else if (pat_bit) begin
      src = SRC_FORE;
      pix = fg;
    end else begin
      src = SRC_BACK;
      pix = bg;
    end
  end

endmodule

// File: rtl/sprite_pixel_compositor.sv
module sprite_pixel_compositor
  import spc_pkg::*;
#(
  parameter int NUM_SPR      = 4,
  parameter int SPR_PAT_W    = 16,
  parameter int BG_PAT_W     = 8,
  parameter int COL_W        = 4,
  parameter int SLOT_W       = 8,
  parameter int PIX_PER_SLOT = 2,
  parameter int WRAP_LIMIT   = 294,
  localparam int SEL_W       = (NUM_SPR > 1) ? $clog2(NUM_SPR) : 1,
  localparam int POS_W       = SLOT_W + 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          slot_en,
  input  logic [SLOT_W-1:0]             hslot,
  input  logic                          active,
  input  logic                          text_mode,
  input  logic [2*COL_W-1:0]            backdrop,
  input  logic                          spr_load,
  input  logic [SEL_W-1:0]              spr_sel,
  input  logic [POS_W-1:0]              spr_x,
  input  logic [COL_W-1:0]              spr_color,
  input  logic [SPR_PAT_W-1:0]          spr_pattern,
  input  logic                          bg_load,
  input  logic [BG_PAT_W-1:0]           bg_pattern,
  input  logic [2*COL_W-1:0]            bg_color,
  input  logic                          coll_clr,
  output logic                          pix_valid,
  output logic [PIX_PER_SLOT*COL_W-1:0] pix_color,
  output logic                          coll_flag
);

  localparam int PPS = PIX_PER_SLOT;

  logic [PPS-1:0][POS_W-1:0] pos;
  logic [PPS-1:0]            lane_bits [NUM_SPR];
  logic [COL_W-1:0]          lane_col  [NUM_SPR];
  logic [PPS-1:0]            bg_msb;
  logic [2*COL_W-1:0]        bg_col;
  logic [PPS-1:0]            spr_hit;
  logic [COL_W-1:0]          spr_pick  [PPS];
  logic [COL_W-1:0]          pix_nx    [PPS];
  pix_src_e                  pix_src   [PPS];
  logic                      coll_now;

  always_comb begin
    int org;
    org = slot_origin(int'(hslot), SLOT_W, WRAP_LIMIT);
    for (int p = 0; p < PPS; p++) pos[p] = POS_W'(org + p);
  end

  for (genvar g = 0; g < NUM_SPR; g++) begin : g_lane
    spc_sprite_lane #(
      .PAT_W(SPR_PAT_W), .POS_W(POS_W), .COL_W(COL_W), .PPS(PPS)
    ) u_lane (
      .clk      (clk),
      .rst      (rst),
      .slot_en  (slot_en),
      .load     (spr_load && (spr_sel == SEL_W'(g))),
      .ld_x     ($signed(spr_x)),
      .ld_color (spr_color),
      .ld_pat   (spr_pattern),
      .pos      (pos),
      .bits     (lane_bits[g]),
      .color    (lane_col[g])
    );
  end

  spc_bg_shift #(
    .PAT_W(BG_PAT_W), .CB_W(2*COL_W), .PPS(PPS)
  ) u_bg (
    .clk     (clk),
    .rst     (rst),
    .load    (bg_load),
    .ld_pat  (bg_pattern),
    .ld_col  (bg_color),
    .consume (slot_en && active),
    .msb     (bg_msb),
    .col     (bg_col)
  );

  // lowest lane with a set, colored bit wins; every set bit counts for collision
  always_comb begin
    coll_now = 1'b0;
    for (int p = 0; p < PPS; p++) begin
      logic [NUM_SPR-1:0] column;
      spr_hit[p]  = 1'b0;
      spr_pick[p] = '0;
      for (int i = NUM_SPR - 1; i >= 0; i--) begin
        column[i] = lane_bits[i][p];
        if (lane_bits[i][p] && (lane_col[i] != '0)) begin
          spr_hit[p]  = 1'b1;
          spr_pick[p] = lane_col[i];
        end
      end
      if ($countones(column) > 1) coll_now = 1'b1;
    end
  end

  for (genvar p = 0; p < PPS; p++) begin : g_pix
    spc_pix_mux #(.COL_W(COL_W)) u_mux (
      .active    (active),
      .text_mode (text_mode),
      .backdrop  (backdrop),
      .col_byte  (bg_col),
      .pat_bit   (bg_msb[p]),
      .spr_hit   (spr_hit[p]),
      .spr_col   (spr_pick[p]),
      .pix       (pix_nx[p]),
      .src       (pix_src[p])
    );

    always_ff @(posedge clk) begin
      if (rst)          pix_color[p*COL_W +: COL_W] <= '0;
      else if (slot_en) pix_color[p*COL_W +: COL_W] <= pix_nx[p];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_valid <= 1'b0;
      coll_flag <= 1'b0;
    end else begin
      pix_valid <= slot_en;
      coll_flag <= (coll_flag && !coll_clr) || (slot_en && coll_now);
    end
  end

  // R10
  border_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (slot_en && !active) |=> (pix_color[COL_W-1:0] == $past(backdrop[COL_W-1:0])));

  // R11
  coll_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (coll_flag && !coll_clr) |=> coll_flag);

  // R11
  coll_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(coll_flag) |-> $past(slot_en));

  // R11
  coll_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (coll_clr && !slot_en) |=> !coll_flag);

  // R2
  valid_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !pix_valid |-> $stable(pix_color));

endmodule

// File: tb/sprite_pixel_compositor_bench.sv
module sprite_pixel_compositor_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        slot_en = 1'b0;
  logic [7:0]  hslot = '0;
  logic        active = 1'b0;
  logic        text_mode = 1'b0;
  logic [7:0]  backdrop = '0;
  logic        spr_load = 1'b0;
  logic [1:0]  spr_sel = '0;
  logic [9:0]  spr_x = '0;
  logic [3:0]  spr_color = '0;
  logic [15:0] spr_pattern = '0;
  logic        bg_load = 1'b0;
  logic [7:0]  bg_pattern = '0;
  logic [7:0]  bg_color = '0;
  logic        coll_clr = 1'b0;
  logic        pix_valid;
  logic [7:0]  pix_color;
  logic        coll_flag;

  always #5 clk = ~clk;

  sprite_pixel_compositor u_sprite_pixel_compositor (
    .clk(clk), .rst(rst), .slot_en(slot_en), .hslot(hslot), .active(active),
    .text_mode(text_mode), .backdrop(backdrop), .spr_load(spr_load),
    .spr_sel(spr_sel), .spr_x(spr_x), .spr_color(spr_color),
    .spr_pattern(spr_pattern), .bg_load(bg_load), .bg_pattern(bg_pattern),
    .bg_color(bg_color), .coll_clr(coll_clr), .pix_valid(pix_valid),
    .pix_color(pix_color), .coll_flag(coll_flag)
  );

  int errors = 0;
  int checks = 0;
  string cur_tag = "R1";
  bit finished = 1'b0;

  // behavioural model state
  int          mx [4];
  int          mc [4];
  logic [15:0] mw [4];
  logic [7:0]  mpat, mcol;
  bit          ev, ecoll;
  int          ep [2];

  task automatic mstep();
    if (rst) begin
      for (int i = 0; i < 4; i++) begin mx[i] = 0; mc[i] = 0; mw[i] = '0; end
      mpat = '0; mcol = '0; ev = 0; ecoll = 0; ep[0] = 0; ep[1] = 0;
      return;
    end
    if (bg_load) begin mpat = bg_pattern; mcol = bg_color; end
    if (spr_load) begin
      mx[spr_sel] = int'($signed(spr_x));
      mc[spr_sel] = int'(spr_color);
      mw[spr_sel] = spr_pattern;
    end
    ev = slot_en;
    if (slot_en) begin
      int base;
      bit newc;
      newc = 0;
      base = int'(hslot) * 2;
      if (base > 294) base -= 512;
      for (int p = 0; p < 2; p++) begin
        int pos, nb, sc, px, fg, bgc;
        bit b;
        pos = base + p; nb = 0; sc = -1;
        for (int i = 0; i < 4; i++) begin
          if (pos >= mx[i]) begin
            b = mw[i][15];
            mw[i] = mw[i] << 1;
            if (b) begin
              nb++;
              if (sc < 0 && mc[i] != 0) sc = mc[i];
            end
          end
        end
        if (nb > 1) newc = 1;
        if (!active) px = int'(backdrop[3:0]);
        else begin
          b = mpat[7];
          mpat = mpat << 1;
          if (sc >= 0) px = sc;
          else if (text_mode) px = b ? int'(backdrop[7:4]) : int'(backdrop[3:0]);
          else begin
            fg = int'(mcol[7:4]);
            bgc = int'(mcol[3:0]);
            if (bgc == 0) bgc = int'(backdrop[3:0]);
            px = b ? fg : bgc;
          end
        end
        ep[p] = px;
      end
      ecoll = (ecoll && !coll_clr) || newc;
    end else begin
      ecoll = ecoll && !coll_clr;
    end
  endtask

  task automatic compare();
    checks++;
    if (pix_valid !== ev || int'(pix_color[3:0]) != ep[0] ||
        int'(pix_color[7:4]) != ep[1] || coll_flag !== ecoll) begin
      errors++;
      $display("FAIL %s: actual valid=%0b pix=%0d,%0d coll=%0b expected valid=%0b pix=%0d,%0d coll=%0b",
               cur_tag, pix_valid, pix_color[3:0], pix_color[7:4], coll_flag,
               ev, ep[0], ep[1], ecoll);
    end
  endtask

  task automatic go();
    mstep();
    @(negedge clk);
    compare();
    slot_en = 0; bg_load = 0; spr_load = 0; coll_clr = 0;
  endtask

  task automatic slot(input int hs, input bit act);
    slot_en = 1; hslot = 8'(hs); active = act;
    go();
  endtask

  task automatic load_spr(input int s, input int x, input int c, input int pat);
    spr_load = 1; spr_sel = 2'(s); spr_x = 10'(x); spr_color = 4'(c); spr_pattern = 16'(pat);
    go();
  endtask

  task automatic load_bg(input int p, input int c);
    bg_load = 1; bg_pattern = 8'(p); bg_color = 8'(c);
    go();
  endtask

  initial begin
    @(negedge clk);
    // R1: reset state
    cur_tag = "R1";
    go(); go(); go();
    rst = 0;
    go(); go();

    // R7 R8: graphics flavor, zero background nibble replaced
    cur_tag = "R7";
    backdrop = 8'h1C; text_mode = 0;
    load_bg(8'hA5, 8'h70);
    for (int h = 10; h < 12; h++) slot(h, 1);
    cur_tag = "R8";
    for (int h = 12; h < 14; h++) slot(h, 1);

    // R9: text flavor
    cur_tag = "R9";
    text_mode = 1; backdrop = 8'hE4;
    load_bg(8'h3C, 8'h55);
    for (int h = 0; h < 4; h++) slot(h, 1);
    text_mode = 0;

    // R4: lane waits for its start position
    cur_tag = "R4";
    load_bg(8'hFF, 8'h21);
    load_spr(0, 40, 5, 16'hF00F);
    for (int h = 18; h < 26; h++) slot(h, 1);

    // R5 R11: overlapping lanes, lowest wins, collision raised
    cur_tag = "R5";
    load_bg(8'h00, 8'h21);
    load_spr(0, 60, 6, 16'hFFFF);
    load_spr(1, 61, 9, 16'hFFFF);
    for (int h = 29; h < 33; h++) slot(h, 1);
    cur_tag = "R11";
    coll_clr = 1; go();
    coll_clr = 1; slot(33, 1);
    go();
    coll_clr = 1; go();
    go();

    // R6: transparent lane over background
    cur_tag = "R6";
    load_bg(8'hF0, 8'hB2);
    load_spr(0, 100, 0, 16'hFFFF);
    load_spr(1, 100, 3, 16'hFF00);
    for (int h = 50; h < 56; h++) slot(h, 1);
    coll_clr = 1; go();

    // R10: border keeps serializing sprites
    cur_tag = "R10";
    load_bg(8'hCC, 8'h87);
    load_spr(2, 150, 4, 16'hFFFF);
    backdrop = 8'h2D;
    for (int h = 75; h < 79; h++) slot(h, 0);
    for (int h = 79; h < 84; h++) slot(h, 1);

    // R3: position fold past the limit, negative start position
    cur_tag = "R3";
    slot(147, 0); slot(148, 0);
    load_spr(3, -20, 11, 16'hC3C3);
    for (int h = 240; h < 256; h++) slot(h, 0);
    load_bg(8'h69, 8'h5E);
    for (int h = 0; h < 4; h++) slot(h, 1);

    // R12: loads coinciding with a slot
    cur_tag = "R12";
    bg_load = 1; bg_pattern = 8'h80; bg_color = 8'h9A;
    slot(100, 1);
    spr_load = 1; spr_sel = 0; spr_x = 10'd0; spr_color = 4'd7; spr_pattern = 16'h8000;
    slot(101, 1);
    slot(102, 1);

    // R2: long random mix of every strobe
    cur_tag = "R2";
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r;
      r = $urandom();
      slot_en   = r[0] | r[1];
      hslot     = hslot + 8'(slot_en);
      active    = r[2] | r[3];
      text_mode = (r[4] & r[5] & r[6]);
      if (r[7] & r[8] & r[9]) backdrop = 8'($urandom());
      coll_clr  = r[10] & r[11] & r[12];
      if (r[13] & r[14]) begin
        bg_load = 1; bg_pattern = 8'($urandom()); bg_color = 8'($urandom());
      end
      if (r[15] & r[16]) begin
        spr_load = 1; spr_sel = r[18:17];
        spr_x = 10'(int'($urandom_range(0, 287)) - 32);
        spr_color = (r[19] & r[20]) ? 4'd0 : 4'($urandom());
        spr_pattern = 16'($urandom());
      end
      go();
    end

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule